// File: doc/BRIEF.md
# Two-Level Branch Target Buffer

This block predicts branch targets for an instruction fetch unit using two storage levels. The first level is a small, fully associative array held in flip-flops. It compares every valid fetch address against all its entries and answers within the same cycle, so fetch can be redirected at its very first stage. The second level is a larger direct-mapped array held in a synchronous memory. It is consulted only when the first level misses and the memory is free. Its answer comes back one cycle later, together with the fetch address it belongs to, so the front-end can redirect at a later stage.

Resolved branches update both levels through one update port. A taken branch installs or refreshes its target. A not-taken branch removes the matching first-level entry and clears the second-level set its address maps to. A second-level hit is also copied into the first level, so the next fetch of that branch hits with no added latency.

Top module: `twoLevelBtb`

## Requirements
- R1: When `fetchValid` is high and the fetch address equals the full address of a valid first-level entry, `earlyHit` is high and `earlyTarget` carries that entry's target in the same cycle. `earlyHit` is low whenever `fetchValid` is low.
- R2: A fetch that misses the first level while `l2Busy` is low starts a second-level lookup. In the next cycle `lateValid` is high and `lateAddr` equals that fetch address. `lateHit` is high with `lateTarget` set when the second-level set holds a valid entry whose tag matches. The set index is address bits [IDX_W+1:2].
- R3: A fetch that hits the first level, or a cycle with `fetchValid` low, starts no lookup, so `lateValid` is low in the next cycle.
- R4: `l2Busy` is high in the cycle after a lookup starts. A first-level miss in that cycle is dropped: it is not queued, and `lateValid` is low in the cycle after it.
- R5: When a lookup returns a hit, its address and target are written into the first level, so a fetch of that address in the next cycle hits early.
- R6: An update with `updTaken` high writes the address and target into both levels. If the address already has a first-level entry, that entry is rewritten in place.
- R7: A first-level allocation takes the entry at a rotating victim pointer, starting from entry 0 after reset. With L1_ENTRIES = 32, the 33rd distinct allocation evicts the first one, and that address then misses early but can still hit late.
- R8: An update with `updTaken` low invalidates any matching first-level entry and clears the valid bit of the second-level set its address indexes.
- R9: Reset (`rstN` low) clears every valid bit in both levels and cancels any outstanding lookup, so `lateValid` and `l2Busy` drop at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | A fetch address is presented this cycle |
| fetchAddr | input | ADDR_W | Fetch address |
| earlyHit | output | 1 | First-level hit, same cycle |
| earlyTarget | output | ADDR_W | First-level predicted target |
| lateValid | output | 1 | A second-level answer is present this cycle |
| lateHit | output | 1 | The second-level answer is a hit |
| lateAddr | output | ADDR_W | Fetch address the late answer belongs to |
| lateTarget | output | ADDR_W | Second-level predicted target |
| l2Busy | output | 1 | Second level occupied; first-level misses are dropped |
| updValid | input | 1 | Resolution update strobe |
| updTaken | input | 1 | Resolved branch was taken |
| updAddr | input | ADDR_W | Address of the resolved branch |
| updTarget | input | ADDR_W | Resolved target |

## Verification
A corrupted first-level valid bit or tag shows up in the same cycle as a wrong `earlyHit` when that address is fetched. A wrong victim pointer only shows up once allocations wrap, as the wrong branch losing its early hit. A stuck pending flag shows up one cycle after a lookup as a missing or extra `lateValid`, or as a `lateAddr` that does not match the fetch. A missing fill or a missed invalidation is visible on the very next fetch of that address.

// File: rtl/btbPkg.sv
package btbPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic l2Read;      // start a second-level lookup at fetchAddr
    logic l1Write;     // write first level (update or fill)
    logic l1Inv;       // invalidate first-level match of updAddr
    logic l1FromFill;  // first-level write source is the late result
    logic l2Write;     // write second level from update
    logic l2Inv;       // clear second-level set of updAddr
  } btbCtlT;

endpackage

// File: rtl/btbSyncMem.sv
module btbSyncMem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 58,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [IW-1:0]    wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic [IW-1:0]    rdIdx,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrIdx] <= wrData;
    if (rdEn) rdData <= mem[rdIdx];
  end
endmodule

// File: rtl/btbCtrl.sv
module btbCtrl
  import btbPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   fetchValid,
  input  logic   earlyHit,
  input  logic   updValid,
  input  logic   updTaken,
  input  logic   lateHitRaw,
  output btbCtlT ctl,
  output logic   pending
);
  logic fillReq;

  always_comb begin
    fillReq        = pending && lateHitRaw;
    ctl.l2Read     = fetchValid && !earlyHit && !pending;
    ctl.l2Write    = updValid && updTaken;
    ctl.l2Inv      = updValid && !updTaken;
    ctl.l1Inv      = updValid && !updTaken;
    ctl.l1FromFill = fillReq && !updValid;
    ctl.l1Write    = (updValid && updTaken) || (fillReq && !updValid);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= ctl.l2Read;
  end

  // R4
  busy_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> !pending);
  // R4
  no_launch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !ctl.l2Read);
  // R3
  no_launch_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (earlyHit || !fetchValid) |=> !pending);
endmodule

// File: rtl/btbDatapath.sv
module btbDatapath
  import btbPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int L1_ENTRIES = 32,
  parameter int L2_SETS    = 64,
  localparam int VIC_W = $clog2(L1_ENTRIES),
  localparam int IDX_W = $clog2(L2_SETS),
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  btbCtlT            ctl,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  output logic              earlyHit,
  output logic [ADDR_W-1:0] earlyTarget,
  output logic              lateHitRaw,
  output logic [ADDR_W-1:0] lateAddr,
  output logic [ADDR_W-1:0] lateTarget
);
  // ---------------- first level ----------------
  logic [L1_ENTRIES-1:0] l1Valid;
  logic [ADDR_W-1:0]     l1Tag [L1_ENTRIES];
  logic [ADDR_W-1:0]     l1Tgt [L1_ENTRIES];
  logic [VIC_W-1:0]      victim;
  logic [L1_ENTRIES-1:0] fetchMatch, wrMatch;
  logic [ADDR_W-1:0]     wrAddr, wrTgt;
  logic                  wrHit;

  assign wrAddr = ctl.l1FromFill ? lateAddr   : updAddr;
  assign wrTgt  = ctl.l1FromFill ? lateTarget : updTarget;

  always_comb begin
    earlyTarget = '0;
    for (int k = 0; k < L1_ENTRIES; k++) begin
      fetchMatch[k] = l1Valid[k] && (l1Tag[k] == fetchAddr);
      wrMatch[k]    = l1Valid[k] && (l1Tag[k] == wrAddr);
      if (fetchMatch[k]) earlyTarget = earlyTarget | l1Tgt[k];
    end
    earlyHit = fetchValid && (|fetchMatch);
    wrHit    = |wrMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l1Valid <= '0;
      victim  <= '0;
    end else begin
      for (int k = 0; k < L1_ENTRIES; k++) begin
        if (ctl.l1Inv && wrMatch[k]) l1Valid[k] <= 1'b0;
        if (ctl.l1Write && (wrHit ? wrMatch[k] : (victim == VIC_W'(k))))
          l1Valid[k] <= 1'b1;
      end
      if (ctl.l1Write && !wrHit)
        victim <= (victim == VIC_W'(L1_ENTRIES - 1)) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < L1_ENTRIES; k++) begin
      if (ctl.l1Write && (wrHit ? wrMatch[k] : (victim == VIC_W'(k)))) begin
        l1Tag[k] <= wrAddr;
        l1Tgt[k] <= wrTgt;
      end
    end
  end

  // R6: an address never occupies two entries
  // R6
  l1_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fetchMatch));

  // ---------------- second level ----------------
  logic [L2_SETS-1:0]        l2Valid;
  logic                      rdValid;
  logic [TAG_W+ADDR_W-1:0]   rdData;
  logic [IDX_W-1:0]          updIdx, fetchIdx;

  assign updIdx   = updAddr[IDX_W+1:2];
  assign fetchIdx = fetchAddr[IDX_W+1:2];

  btbSyncMem #(.DEPTH(L2_SETS), .WIDTH(TAG_W + ADDR_W)) l2Mem (
    .clk   (clk),
    .wrEn  (ctl.l2Write),
    .wrIdx (updIdx),
    .wrData({updAddr[ADDR_W-1:IDX_W+2], updTarget}),
    .rdEn  (ctl.l2Read),
    .rdIdx (fetchIdx),
    .rdData(rdData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l2Valid <= '0;
      rdValid <= 1'b0;
      lateAddr <= '0;
    end else begin
      if (ctl.l2Write)     l2Valid[updIdx] <= 1'b1;
      else if (ctl.l2Inv)  l2Valid[updIdx] <= 1'b0;
      if (ctl.l2Read) begin
        rdValid  <= l2Valid[fetchIdx];
        lateAddr <= fetchAddr;
      end
    end
  end

  assign lateTarget = rdData[ADDR_W-1:0];
  assign lateHitRaw = rdValid &&
                      (rdData[TAG_W+ADDR_W-1:ADDR_W] == lateAddr[ADDR_W-1:IDX_W+2]);
endmodule

// File: rtl/twoLevelBtb.sv
module twoLevelBtb #(
  parameter int ADDR_W     = 32,
  parameter int L1_ENTRIES = 32,
  parameter int L2_SETS    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              earlyHit,
  output logic [ADDR_W-1:0] earlyTarget,
  output logic              lateValid,
  output logic              lateHit,
  output logic [ADDR_W-1:0] lateAddr,
  output logic [ADDR_W-1:0] lateTarget,
  output logic              l2Busy,
  input  logic              updValid,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget
);
  btbPkg::btbCtlT ctl;
  logic pending, lateHitRaw;

  btbCtrl ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .earlyHit(earlyHit),
    .updValid(updValid), .updTaken(updTaken), .lateHitRaw(lateHitRaw),
    .ctl(ctl), .pending(pending)
  );

  btbDatapath #(.ADDR_W(ADDR_W), .L1_ENTRIES(L1_ENTRIES), .L2_SETS(L2_SETS)) dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fetchValid(fetchValid),
    .fetchAddr(fetchAddr), .updAddr(updAddr), .updTarget(updTarget),
    .earlyHit(earlyHit), .earlyTarget(earlyTarget), .lateHitRaw(lateHitRaw),
    .lateAddr(lateAddr), .lateTarget(lateTarget)
  );

  assign lateValid = pending;
  assign lateHit   = pending && lateHitRaw;
  assign l2Busy    = pending;

  // R2
  late_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    lateValid |-> (lateAddr == $past(fetchAddr)));
endmodule

// File: tb/twoLevelBtb_test.sv
`timescale 1ns/1ps
module twoLevelBtb_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        earlyHit, lateValid, lateHit, l2Busy;
  logic [31:0] earlyTarget, lateAddr, lateTarget;
  logic        updValid = 1'b0, updTaken = 1'b0;
  logic [31:0] updAddr = '0, updTarget = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twoLevelBtb uut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .earlyHit(earlyHit), .earlyTarget(earlyTarget), .lateValid(lateValid),
    .lateHit(lateHit), .lateAddr(lateAddr), .lateTarget(lateTarget),
    .l2Busy(l2Busy), .updValid(updValid), .updTaken(updTaken),
    .updAddr(updAddr), .updTarget(updTarget)
  );

  function automatic logic [31:0] addrOf(int i); return 32'h0000_1000 + i * 4; endfunction
  function automatic logic [31:0] tgtOf(int i);  return 32'h0008_0000 + i * 16; endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs at the falling edge; checks follow 1 ns later
  task automatic step(logic fv, logic [31:0] fa, logic uv, logic ut,
                      logic [31:0] ua, logic [31:0] ut2);
    @(negedge clk);
    fetchValid = fv; fetchAddr = fa;
    updValid = uv; updTaken = ut; updAddr = ua; updTarget = ut2;
    #1;
  endtask

  task automatic idle(); step(0, '0, 0, 0, '0, '0); endtask

  task automatic testReset();
    step(1, addrOf(0), 0, 0, '0, '0);
    chk("R9", "earlyHit after reset", earlyHit, 0);
    chk("R9", "l2Busy after reset", l2Busy, 0);
    chk("R9", "lateValid after reset", lateValid, 0);
    idle();
    chk("R2", "lateValid for miss", lateValid, 1);
    chk("R9", "lateHit with cleared L2", lateHit, 0);
    chk("R2", "lateAddr", lateAddr, addrOf(0));
  endtask

  task automatic testFill();
    for (int i = 0; i < 33; i++) step(0, '0, 1, 1, addrOf(i), tgtOf(i));
    step(0, addrOf(5), 0, 0, '0, '0);
    chk("R1", "earlyHit without fetchValid", earlyHit, 0);
    step(1, addrOf(5), 0, 0, '0, '0);
    chk("R1", "earlyHit", earlyHit, 1);
    chk("R6", "earlyTarget", earlyTarget, tgtOf(5));
    idle();
    chk("R3", "no lookup after early hit", lateValid, 0);
  endtask

  task automatic testEvictAndBusy();
    step(1, addrOf(0), 0, 0, '0, '0);
    chk("R7", "evicted entry misses early", earlyHit, 0);
    step(1, addrOf(40), 0, 0, '0, '0);
    chk("R4", "l2Busy after launch", l2Busy, 1);
    chk("R7", "lateHit for evicted entry", lateHit, 1);
    chk("R6", "lateTarget from L2", lateTarget, tgtOf(0));
    chk("R2", "lateAddr", lateAddr, addrOf(0));
    step(1, addrOf(0), 0, 0, '0, '0);
    chk("R5", "filled entry hits early", earlyHit, 1);
    chk("R5", "filled target", earlyTarget, tgtOf(0));
    chk("R4", "dropped miss gives no result", lateValid, 0);
    idle();
    chk("R3", "no lookup after hit", lateValid, 0);
  endtask

  task automatic testInPlace();
    step(0, '0, 1, 1, addrOf(2), 32'h0000_ABC0);
    step(1, addrOf(2), 0, 0, '0, '0);
    chk("R6", "in-place rewrite hit", earlyHit, 1);
    chk("R6", "in-place rewrite target", earlyTarget, 32'h0000_ABC0);
    idle();
  endtask

  task automatic testNotTaken();
    step(0, '0, 1, 0, addrOf(3), '0);
    step(1, addrOf(3), 0, 0, '0, '0);
    chk("R8", "invalidated L1 entry", earlyHit, 0);
    idle();
    chk("R8", "lateValid", lateValid, 1);
    chk("R8", "invalidated L2 set", lateHit, 0);
  endtask

  task automatic testResetAbort();
    step(1, addrOf(1), 0, 0, '0, '0);
    chk("R7", "second eviction misses early", earlyHit, 0);
    idle();
    chk("R4", "busy before reset", l2Busy, 1);
    @(negedge clk); rstN = 1'b0; #1;
    chk("R9", "lateValid cleared by reset", lateValid, 0);
    chk("R9", "l2Busy cleared by reset", l2Busy, 0);
    @(negedge clk); rstN = 1'b1;
    step(1, addrOf(4), 0, 0, '0, '0);
    chk("R9", "L1 cleared by reset", earlyHit, 0);
    idle();
    chk("R9", "L2 cleared by reset", lateHit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFill();
    testEvictAndBusy();
    testInPlace();
    testNotTaken();
    testResetAbort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule